// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle register datapath driven by one packed control word per clock. The word names a destination register, two source registers, the operation of a function unit, and two one-bit source selectors. The register file has one write port and two combinational read ports. A selector on the second operand path picks either a register or an external constant. A second selector on the write-back path picks either the function unit output or an external data word.

A sequencer outside the block presents a new control word every cycle. The block shows the operand buses, the function unit result and four status flags (sign, zero, carry, signed overflow) combinationally for that word. When the write-enable bit of the word is set, the block stores the chosen write-back value into the destination register on the rising clock edge.

The register count and the data width are parameters. The address fields are log2 of the register count wide.

Top module: `cw_datapath`

## Requirements
- R1: While reset is asserted and after it is released, register i holds the value i, truncated to the data width, until the first write to it.
- R2: The control word is 3*ADDR_W+8 bits wide. From most to least significant bit it holds the destination address (ADDR_W bits), the A source address (ADDR_W bits), the B source address (ADDR_W bits), the B-select bit, the 5-bit function code, the write-back select bit, and the write-enable bit. With 8 registers, the word 001 010 011 0 00101 0 1 writes R2 + ~R3 + 1 into R1.
- R3: `a_bus` always equals the register addressed by the A field. With B-select at 0, `b_bus` equals the register addressed by the B field. Both are combinational.
- R4: With B-select at 1, `b_bus` equals `const_in`, and the function unit uses it as its B operand.
- R5: With write-enable at 1 and write-back select at 0, `result` is stored into the destination register on the rising edge. A read of that register in the same cycle still returns the old value, and a read in the next cycle returns the new value.
- R6: With write-enable at 1 and write-back select at 1, `data_in` is stored into the destination register, whatever the value of `result`.
- R7: With write-enable at 0, no register changes, whatever the values of the destination, write-back select, `data_in` and function fields.
- R8: Function codes with the top two bits 00 are arithmetic, result = A + Y + code[0]. Y is selected by code[2:1]: 00 gives zero, 01 gives B, 10 gives ~B, 11 gives all ones. So 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00011 gives A+B+1, 00100 gives A+~B, 00101 gives A-B, 00110 gives A-1, and 00111 gives A.
- R9: Function codes with the top bits 01 are logic operations selected by code[2:1]: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, 11 gives NOT A. code[0] is ignored.
- R10: Function codes with code[4]=1 act on B and are selected by code[3:2]: 01 gives a logical shift right by one, 10 gives a shift left by one (zero filled in both cases), and 00 or 11 pass B through. code[1:0] are ignored.
- R11: `flag_n` is the result MSB and `flag_z` is 1 when the result is zero. For arithmetic codes, `flag_c` is the carry out of the MSB and `flag_v` is 1 on signed overflow. For the logic and B codes, `flag_c` and `flag_v` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 3*ADDR_W+8 | Packed control word |
| const_in | input | DATA_W | Constant offered to the B operand selector |
| data_in | input | DATA_W | External data offered to the write-back selector |
| a_bus | output | DATA_W | A operand (register read port A) |
| b_bus | output | DATA_W | B operand after the B selector |
| result | output | DATA_W | Function unit output |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Sign (result MSB) |
| flag_z | output | 1 | Result is zero |

## Verification
The assertions check the following relations on every cycle:
- the constant selection on the B path;
- agreement of the two read ports when they address the same register;
- write-back of `result` or `data_in` as seen on the A bus in the next cycle;
- unchanged contents when write-enable is low;
- zero carry and overflow for non-arithmetic codes.

Only the bench's scenarios can show some other behaviours. These are the reset contents of every register, the exact value of each function code, and the flag values at the signed and unsigned boundaries (7F+1, FF+1, 80-1). They also include reads of registers that no assertion happens to address in the cycle after a write.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
   localparam int FS_W = 5;

   // Upper bits of the function code select the operation group
   typedef enum logic [1:0] {
      GRP_ARITH = 2'b00,
      GRP_LOGIC = 2'b01,
      GRP_BOPA  = 2'b10,
      GRP_BOPB  = 2'b11
   } fs_grp_e;

   typedef enum logic [1:0] {
      LOG_AND  = 2'b00,
      LOG_OR   = 2'b01,
      LOG_XOR  = 2'b10,
      LOG_NOTA = 2'b11
   } fs_logic_e;

   typedef enum logic [1:0] {
      BOP_PASS0 = 2'b00,
      BOP_SHR   = 2'b01,
      BOP_SHL   = 2'b10,
      BOP_PASS1 = 2'b11
   } fs_bop_e;

   function automatic int cw_width(input int aw);
      return 3 * aw + 8;
   endfunction
endpackage

// File: rtl/cwdp_cw_decode.sv
module cwdp_cw_decode
   import cwdp_pkg::*;
#(
   parameter int ADDR_W = 3,
   localparam int CW_W  = cw_width(ADDR_W)
) (
   input  logic [CW_W-1:0]   ctrl_word,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [ADDR_W-1:0] srca_addr,
   output logic [ADDR_W-1:0] srcb_addr,
   output logic              bsel_const,
   output logic [FS_W-1:0]   func_code,
   output logic              wb_ext,
   output logic              wr_en
);
   localparam int WE_LSB  = 0;
   localparam int WB_LSB  = WE_LSB + 1;
   localparam int FS_LSB  = WB_LSB + 1;
   localparam int BS_LSB  = FS_LSB + FS_W;
   localparam int SB_LSB  = BS_LSB + 1;
   localparam int SA_LSB  = SB_LSB + ADDR_W;
   localparam int DST_LSB = SA_LSB + ADDR_W;

   assign wr_en      = ctrl_word[WE_LSB];
   assign wb_ext     = ctrl_word[WB_LSB];
   assign func_code  = ctrl_word[FS_LSB +: FS_W];
   assign bsel_const = ctrl_word[BS_LSB];
   assign srcb_addr  = ctrl_word[SB_LSB +: ADDR_W];
   assign srca_addr  = ctrl_word[SA_LSB +: ADDR_W];
   assign dst_addr   = ctrl_word[DST_LSB +: ADDR_W];
endmodule

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      if (NUM_REGS != (1 << ADDR_W)) begin : g_bad_depth
         $error("cwdp_regfile: NUM_REGS must equal 2**ADDR_W");
      end
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= DATA_W'(i);
            else if (we && (waddr == ADDR_W'(i)))
               regs[i] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/cwdp_func_unit.sv
module cwdp_func_unit
   import cwdp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [FS_W-1:0]   func_code,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] g,
   output logic              cout,
   output logic              ovf,
   output logic              neg,
   output logic              zero
);
   logic [DATA_W-1:0] yop;
   logic [DATA_W:0]   full_sum;
   logic [DATA_W-1:0] low_sum;
   logic              cin;
   fs_grp_e           grp;

   assign grp = fs_grp_e'(func_code[4:3]);
   assign cin = func_code[0];

   always_comb begin
      unique case (func_code[2:1])
         2'b00:   yop = '0;
         2'b01:   yop = opb;
         2'b10:   yop = ~opb;
         default: yop = '1;
      endcase
      full_sum = {1'b0, opa} + {1'b0, yop} + {{DATA_W{1'b0}}, cin};
      low_sum  = {1'b0, opa[DATA_W-2:0]} + {1'b0, yop[DATA_W-2:0]}
               + {{(DATA_W-1){1'b0}}, cin};
   end

   always_comb begin
      cout = 1'b0;
      ovf  = 1'b0;
      g    = opb;
      if (grp == GRP_ARITH) begin
         g    = full_sum[DATA_W-1:0];
         cout = full_sum[DATA_W];
         ovf  = full_sum[DATA_W] ^ low_sum[DATA_W-1];
      end else if (grp == GRP_LOGIC) begin
         unique case (fs_logic_e'(func_code[2:1]))
            LOG_AND: g = opa & opb;
            LOG_OR:  g = opa | opb;
            LOG_XOR: g = opa ^ opb;
            default: g = ~opa;
         endcase
      end else begin
         unique case (fs_bop_e'(func_code[3:2]))
            BOP_SHR: g = {1'b0, opb[DATA_W-1:1]};
            BOP_SHL: g = {opb[DATA_W-2:0], 1'b0};
            default: g = opb;
         endcase
      end
   end

   assign neg  = g[DATA_W-1];
   assign zero = ~|g;
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
   import cwdp_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 8,
   localparam int ADDR_W  = $clog2(NUM_REGS),
   localparam int CW_W    = cw_width(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   ctrl_word,
   input  logic [DATA_W-1:0] const_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] a_bus,
   output logic [DATA_W-1:0] b_bus,
   output logic [DATA_W-1:0] result,
   output logic              flag_v,
   output logic              flag_c,
   output logic              flag_n,
   output logic              flag_z
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cw_datapath: DATA_W must be at least 2");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("cw_datapath: NUM_REGS must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] dst_addr, srca_addr, srcb_addr;
   logic              bsel_const, wb_ext, wr_en;
   logic [FS_W-1:0]   func_code;
   logic [DATA_W-1:0] rd_b, wb_data;

   cwdp_cw_decode #(.ADDR_W(ADDR_W)) u_dec (
      .ctrl_word  (ctrl_word),
      .dst_addr   (dst_addr),
      .srca_addr  (srca_addr),
      .srcb_addr  (srcb_addr),
      .bsel_const (bsel_const),
      .func_code  (func_code),
      .wb_ext     (wb_ext),
      .wr_en      (wr_en)
   );

   cwdp_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (dst_addr),
      .wdata   (wb_data),
      .raddr_a (srca_addr),
      .raddr_b (srcb_addr),
      .rdata_a (a_bus),
      .rdata_b (rd_b)
   );

   assign b_bus   = bsel_const ? const_in : rd_b;
   assign wb_data = wb_ext ? data_in : result;

   cwdp_func_unit #(.DATA_W(DATA_W)) u_fu (
      .func_code (func_code),
      .opa       (a_bus),
      .opb       (b_bus),
      .g         (result),
      .cout      (flag_c),
      .ovf       (flag_v),
      .neg       (flag_n),
      .zero      (flag_z)
   );
endmodule

// File: rtl/cwdp_checker.sv
module cwdp_checker #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   localparam int CW_W  = 3 * ADDR_W + 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CW_W-1:0]   ctrl_word,
   input logic [DATA_W-1:0] const_in,
   input logic [DATA_W-1:0] data_in,
   input logic [DATA_W-1:0] a_bus,
   input logic [DATA_W-1:0] b_bus,
   input logic [DATA_W-1:0] result,
   input logic              flag_v,
   input logic              flag_c
);
   logic [ADDR_W-1:0] k_da, k_aa, k_ba;
   logic              k_mb, k_md, k_rw;
   logic [4:0]        k_fs;

   assign {k_da, k_aa, k_ba, k_mb, k_fs, k_md, k_rw} = ctrl_word;

   p_bconst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      k_mb |-> (b_bus == const_in));

   p_same_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!k_mb && (k_ba == k_aa)) |-> (b_bus == a_bus));

   p_wb_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (k_rw && !k_md) |=> ((k_aa != $past(k_da)) || (a_bus == $past(result))));

   p_wb_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (k_rw && k_md) |=> ((k_aa != $past(k_da)) || (a_bus == $past(data_in))));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !k_rw |=> ((k_aa != $past(k_aa)) || (a_bus == $past(a_bus))));

   p_pass_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (k_fs == 5'b00000) |-> ((result == a_bus) && !flag_c && !flag_v));

   p_noarith_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (k_fs[4] || k_fs[3]) |-> (!flag_c && !flag_v));
endmodule

bind cw_datapath cwdp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_word (ctrl_word),
   .const_in  (const_in),
   .data_in   (data_in),
   .a_bus     (a_bus),
   .b_bus     (b_bus),
   .result    (result),
   .flag_v    (flag_v),
   .flag_c    (flag_c)
);

// File: tb/cw_datapath_bench.sv
`timescale 1ns/1ps
module cw_datapath_bench;
   localparam int NR = 8;
   localparam int W  = 8;
   localparam int CW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] ctrl_word = '0;
   logic [W-1:0]  const_in = '0, data_in = '0;
   logic [W-1:0]  a_bus, b_bus, result;
   logic          flag_v, flag_c, flag_n, flag_z;

   int n_checks = 0, n_fail = 0;
   int mreg [NR];

   always #5 clk = ~clk;

   cw_datapath #(.NUM_REGS(NR), .DATA_W(W)) u_cw_datapath (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .const_in(const_in),
      .data_in(data_in), .a_bus(a_bus), .b_bus(b_bus), .result(result),
      .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z));

   function automatic logic [CW-1:0] mk(int da, int aa, int ba, int mb, int fs, int md, int rw);
      return {da[2:0], aa[2:0], ba[2:0], mb[0], fs[4:0], md[0], rw[0]};
   endfunction

   // behavioural function model, integer arithmetic
   task automatic model(input int fs, input int a, input int b,
                        output int g, output int c, output int v);
      int y, s;
      c = 0; v = 0; y = 0;
      if (fs >= 16) begin
         case ((fs >> 2) & 3)
            1: g = b >> 1;
            2: g = (b << 1) & 255;
            default: g = b;
         endcase
      end else if (fs >= 8) begin
         case ((fs >> 1) & 3)
            0: g = a & b;
            1: g = a | b;
            2: g = a ^ b;
            default: g = (~a) & 255;
         endcase
      end else begin
         case ((fs >> 1) & 3)
            0: y = 0;
            1: y = b;
            2: y = (~b) & 255;
            default: y = 255;
         endcase
         s = a + y + (fs & 1);
         g = s & 255;
         c = (s >> 8) & 1;
         v = ((((a ^ y) & 128) == 0) && (((a ^ g) & 128) != 0)) ? 1 : 0;
      end
   endtask

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input string tag, input logic [CW-1:0] cw,
                        input int k, input int d);
      int da, aa, ba, mb, fs, md, rw, ea, eb, g, c, v;
      @(negedge clk);
      ctrl_word = cw; const_in = k[W-1:0]; data_in = d[W-1:0];
      #1;
      da = int'(cw[16:14]); aa = int'(cw[13:11]); ba = int'(cw[10:8]);
      mb = int'(cw[7]); fs = int'(cw[6:2]); md = int'(cw[1]); rw = int'(cw[0]);
      ea = mreg[aa];
      eb = (mb != 0) ? (k & 255) : mreg[ba];
      model(fs, ea, eb, g, c, v);
      chk(tag, "a_bus", int'(a_bus), ea);
      chk(tag, "b_bus", int'(b_bus), eb);
      chk(tag, "result", int'(result), g);
      chk(tag, "flags vcnz", int'({flag_v, flag_c, flag_n, flag_z}),
          (v << 3) | (c << 2) | (((g >> 7) & 1) << 1) | ((g == 0) ? 1 : 0));
      if (rw != 0) mreg[da] = (md != 0) ? (d & 255) : g;
   endtask

   task automatic load(int r, int val);
      apply("R6 load", mk(r, 0, 0, 0, 0, 1, 1), 0, val);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) mreg[i] = i;
      #1;
      // R1: reset contents visible while reset is held
      chk("R1 during reset", "a_bus", int'(a_bus), 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < NR; i++) apply("R1 reset value", mk(0, i, 7 - i, 0, 0, 0, 0), 0, 0);

      // R2: documented example word, then read back R1
      apply("R2 example word", 17'b001_010_011_0_00101_0_1, 0, 0);
      apply("R2 readback", mk(0, 1, 1, 0, 0, 0, 0), 0, 0);
      chk("R2 R1 = 2-3", "model", mreg[1], 255);

      // R3: read port pairs
      apply("R3 read pair", mk(0, 5, 6, 0, 2, 0, 0), 0, 0);
      apply("R3 read pair", mk(0, 7, 0, 0, 2, 0, 0), 0, 0);

      // R4: constant path
      apply("R4 const", mk(0, 3, 4, 1, 2, 0, 0), 8'h5A, 0);
      apply("R4 const", mk(2, 4, 0, 1, 2, 0, 1), 8'hF0, 0);
      apply("R4 const readback", mk(0, 2, 2, 0, 0, 0, 0), 0, 0);

      // R5: write result, same-cycle read old, next cycle new
      apply("R5 write", mk(6, 6, 6, 1, 1, 0, 1), 0, 0);
      apply("R5 next cycle", mk(6, 6, 6, 0, 1, 0, 1), 0, 0);
      apply("R5 next cycle", mk(0, 6, 6, 0, 0, 0, 0), 0, 0);

      // R6: external data wins over result
      apply("R6 ext data", mk(3, 1, 2, 0, 2, 1, 1), 0, 8'hC3);
      apply("R6 readback", mk(0, 3, 3, 0, 0, 0, 0), 0, 0);

      // R7: no write when write-enable is low
      apply("R7 no write", mk(3, 3, 3, 0, 1, 1, 0), 0, 8'h11);
      apply("R7 no write", mk(5, 0, 0, 0, 1, 0, 0), 0, 0);
      for (int i = 0; i < NR; i++) apply("R7 contents", mk(0, i, i, 0, 0, 0, 0), 0, 0);

      // R8 / R11 boundaries
      load(1, 8'h7F); load(2, 8'h01); load(3, 8'hFF); load(4, 8'h80); load(5, 8'h00);
      for (int f = 0; f < 8; f++) begin
         apply("R8 arith 7F,01", mk(0, 1, 2, 0, f, 0, 0), 0, 0);
         apply("R8 arith FF,FF", mk(0, 3, 3, 0, f, 0, 0), 0, 0);
         apply("R8 arith 80,00", mk(0, 4, 5, 0, f, 0, 0), 0, 0);
      end
      apply("R11 7F+1 overflow", mk(0, 1, 0, 0, 1, 0, 0), 0, 0);
      apply("R11 FF+1 carry zero", mk(0, 3, 0, 0, 1, 0, 0), 0, 0);
      apply("R11 80-1", mk(0, 4, 0, 0, 6, 0, 0), 0, 0);
      apply("R11 80-01 overflow", mk(0, 4, 2, 0, 5, 0, 0), 0, 0);

      // R9 / R10 every non-arithmetic code
      for (int f = 8; f < 32; f++) begin
         apply("R9 R10 code 7F,80", mk(0, 1, 4, 0, f, 0, 0), 0, 0);
         apply("R9 R10 code FF,const", mk(0, 3, 0, 1, f, 0, 0), 8'hA5, 0);
      end

      // random mix across all fields
      for (int t = 0; t < 600; t++)
         apply("R11 R5 random mix", 17'($urandom), int'($urandom & 255), int'($urandom & 255));

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule